// File: doc/BRIEF.md
# Coprocessor Context Save/Restore Sequencer

This block sits on the main-processor side of a register-mapped coprocessor link and carries out one context save or one context restore per request. A save first asks the coprocessor for its 16-bit format word. A restore first fetches that word from memory at the effective address supplied with the request. The word is then validated. A word equal to the reserved invalid code (which a coprocessor also returns when it is still busy with an earlier save or restore) is rejected. So is a word whose byte-length field is not a whole number of 32-bit words. On either rejection the sequencer writes an abort mask to the coprocessor control register and raises a format-error exception.

When the word is accepted, its length field sets the size of the state frame. The format word is written to its destination first. The frame then moves one 32-bit word at a time: from the coprocessor operand register to memory on a save, and from memory to the operand register on a restore. Each word costs one read handshake on the source port and one write handshake on the destination port. Completion is signalled once the last write is acknowledged. Effective-address calculation, instruction decode and exception handling belong to the surrounding core.

The control is one state machine with states IDLE, READ_FMT, CHECK, XFER, ABORT and DONE. XFER steps through three phases: FMT (write the format word), SRC (read a frame word) and DST (write it). The transitions are:
- IDLE→READ_FMT on start.
- READ_FMT→CHECK on the acknowledge of the format read.
- CHECK→ABORT when the word is rejected; CHECK→XFER (phase FMT) when it is accepted.
- XFER FMT→DONE when the length is zero; FMT→SRC otherwise.
- XFER SRC→DST on the read acknowledge.
- XFER DST→SRC for the next word; DST→DONE after the last word.
- ABORT→DONE on the control-write acknowledge.
- DONE→IDLE unconditionally.

Top module: `cpctx_seq`

## Requirements
- R1: A start pulse is taken only in IDLE, and busy is high from the next cycle until the cycle after DONE. A start seen while busy has no effect on the port traffic or on the outcome of the running operation.
- R2: A save begins with one read of the coprocessor save register (cp_sel = 1). Every coprocessor access carries cp_id equal to the 3-bit identifier field taken from instruction bits 11 to 9 at start.
- R3: A restore begins with one memory read at the effective address. The format word is bits 15:0 of the word returned.
- R4: A format word equal to INVALID_FMT (default 16'h0100, also the busy reply) causes exactly one write of ABORT_MASK to the control register (cp_sel = 0), followed by a one-cycle fmt_err pulse. No frame word and no format word is written anywhere.
- R5: The length field is bits 7:0 of the format word, counted in bytes. A length with bit 1 or bit 0 set is rejected exactly as in R4, on both save and restore.
- R6: An accepted save writes {16'h0, format} to memory at the effective address. Then, for k = 0 to length/4-1 in increasing order, it reads the operand register (cp_sel = 3) and writes that value to effective address + 4 + 4k.
- R7: An accepted restore writes {16'h0, format} to the restore register (cp_sel = 2). Then, for k in increasing order, it reads memory at effective address + 4 + 4k and writes that value to the operand register.
- R8: A length of zero is accepted, and only the format word is moved.
- R9: done is a one-cycle pulse in the cycle after the final write acknowledge. done and fmt_err are never high together.
- R10: At most one of mem_req and cp_req is high in any cycle. A request holds its address, select, direction and data stable until it is acknowledged.
- R11: After reset the block is idle, with no request, done or fmt_err asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken in IDLE |
| op_restore | input | 1 | 1 = restore, 0 = save |
| op_cpid | input | 3 | Coprocessor identifier field (instruction bits 11:9) |
| ea_addr | input | AW | Effective address of the state frame |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Successful completion pulse |
| fmt_err | output | 1 | Format-error exception pulse |
| cp_req | output | 1 | Coprocessor register access request |
| cp_we | output | 1 | 1 = write, 0 = read |
| cp_id | output | 3 | Selected coprocessor |
| cp_sel | output | 2 | Register: 0 control, 1 save, 2 restore, 3 operand |
| cp_wdata | output | DW | Coprocessor write data |
| cp_rdata | input | DW | Coprocessor read data, valid with cp_ack |
| cp_ack | input | 1 | Coprocessor access acknowledge |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
A wrong state or phase shows at the ports at the next handshake. It appears as a request on the wrong port, a wrong register select, an address that skips or repeats a frame word, or a write of stale buffered data. Each of these appears in the transaction trace within a few cycles of the fault. A corrupted length or word count shows up as a trace that is too short or too long before done. A lost error flag shows up as done instead of fmt_err in the single DONE cycle. Because each operation's complete trace is compared in order, a fault is caught by the end of the operation in which it occurs.

// File: rtl/cpctx_pkg.sv
package cpctx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READ_FMT = 3'd1,
        ST_CHECK    = 3'd2,
        ST_XFER     = 3'd3,
        ST_ABORT    = 3'd4,
        ST_DONE     = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_FMT = 2'd0,
        PH_SRC = 2'd1,
        PH_DST = 2'd2
    } xfer_phase_e;

    // coprocessor register selects
    localparam logic [1:0] CPR_CTRL    = 2'd0;
    localparam logic [1:0] CPR_SAVE    = 2'd1;
    localparam logic [1:0] CPR_RESTORE = 2'd2;
    localparam logic [1:0] CPR_OPERAND = 2'd3;

endpackage

// File: rtl/cpctx_fmt_check.sv
module cpctx_fmt_check #(
    parameter int                FMT_W       = 16,
    parameter int                LEN_W       = 8,
    parameter logic [FMT_W-1:0]  INVALID_FMT = 16'h0100
) (
    input  logic [FMT_W-1:0]  fmt,
    output logic              is_invalid,
    output logic              len_bad,
    output logic [LEN_W-3:0]  word_cnt
);
    // reserved code, also the reply of a coprocessor that is still busy
    assign is_invalid = (fmt == INVALID_FMT);
    // byte length must cover whole 32-bit words
    assign len_bad    = |fmt[1:0];
    assign word_cnt   = fmt[LEN_W-1:2];
endmodule

// File: rtl/cpctx_frame_ptr.sv
module cpctx_frame_ptr #(
    parameter int AW    = 32,
    parameter int CNT_W = 6,
    parameter int STEP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic [AW-1:0]     base,
    input  logic              load_cnt,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              advance,
    output logic [AW-1:0]     addr,
    output logic              last,
    output logic              empty
);
    localparam logic [AW-1:0] STEP_A = AW'(STEP);

    logic [AW-1:0]    addr_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (load_base) begin
                addr_q <= base + STEP_A;
                idx_q  <= '0;
            end else if (advance) begin
                addr_q <= addr_q + STEP_A;
                idx_q  <= idx_q + 1'b1;
            end
            if (load_cnt) begin
                cnt_q <= cnt_in;
            end
        end
    end

    assign addr  = addr_q;
    assign empty = (cnt_q == '0);
    assign last  = (({1'b0, idx_q} + (CNT_W+1)'(1)) == {1'b0, cnt_q});

    AST_PTR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (idx_q < cnt_q)); // R6

endmodule

// File: rtl/cpctx_seq.sv
module cpctx_seq
    import cpctx_pkg::*;
#(
    parameter int               AW          = 32,
    parameter int               DW          = 32,
    parameter int               FMT_W       = 16,
    parameter int               LEN_W       = 8,
    parameter logic [FMT_W-1:0] INVALID_FMT = 16'h0100,
    parameter logic [DW-1:0]    ABORT_MASK  = 32'h0000_0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_restore,
    input  logic [2:0]      op_cpid,
    input  logic [AW-1:0]   ea_addr,
    output logic            busy,
    output logic            done,
    output logic            fmt_err,
    output logic            cp_req,
    output logic            cp_we,
    output logic [2:0]      cp_id,
    output logic [1:0]      cp_sel,
    output logic [DW-1:0]   cp_wdata,
    input  logic [DW-1:0]   cp_rdata,
    input  logic            cp_ack,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack
);
    localparam int CNT_W = LEN_W - 2;
    localparam int STEP  = DW / 8;

    seq_state_e  state_q, state_d;
    xfer_phase_e phase_q, phase_d;

    logic             restore_q;
    logic [2:0]       id_q;
    logic [AW-1:0]    base_q;
    logic [FMT_W-1:0] fmt_q;
    logic [DW-1:0]    buf_q;
    logic             err_q;

    logic             fmt_invalid, fmt_len_bad;
    logic [CNT_W-1:0] fmt_words;
    logic [AW-1:0]    frame_addr;
    logic             frame_last, frame_empty;

    logic src_ack, dst_ack;
    logic take_start, ptr_advance;

    // save: coprocessor -> memory; restore: memory -> coprocessor
    assign src_ack     = restore_q ? mem_ack : cp_ack;
    assign dst_ack     = restore_q ? cp_ack  : mem_ack;
    assign take_start  = (state_q == ST_IDLE) && start;
    assign ptr_advance = (state_q == ST_XFER) && (phase_q == PH_DST) && dst_ack;

    cpctx_fmt_check #(
        .FMT_W       (FMT_W),
        .LEN_W       (LEN_W),
        .INVALID_FMT (INVALID_FMT)
    ) u_fmt (
        .fmt        (fmt_q),
        .is_invalid (fmt_invalid),
        .len_bad    (fmt_len_bad),
        .word_cnt   (fmt_words)
    );

    cpctx_frame_ptr #(
        .AW    (AW),
        .CNT_W (CNT_W),
        .STEP  (STEP)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (take_start),
        .base      (ea_addr),
        .load_cnt  (state_q == ST_CHECK),
        .cnt_in    (fmt_words),
        .advance   (ptr_advance),
        .addr      (frame_addr),
        .last      (frame_last),
        .empty     (frame_empty)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_READ_FMT;
            end
            ST_READ_FMT: begin
                if (src_ack) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (fmt_invalid || fmt_len_bad) begin
                    state_d = ST_ABORT;
                end else begin
                    state_d = ST_XFER;
                    phase_d = PH_FMT;
                end
            end
            ST_XFER: begin
                unique case (phase_q)
                    PH_FMT: begin
                        if (dst_ack) begin
                            if (frame_empty) state_d = ST_DONE;
                            else             phase_d = PH_SRC;
                        end
                    end
                    PH_SRC: begin
                        if (src_ack) phase_d = PH_DST;
                    end
                    PH_DST: begin
                        if (dst_ack) begin
                            if (frame_last) state_d = ST_DONE;
                            else            phase_d = PH_SRC;
                        end
                    end
                    default: phase_d = PH_FMT;
                endcase
            end
            ST_ABORT: begin
                if (cp_ack) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_FMT;
            restore_q <= 1'b0;
            id_q      <= '0;
            base_q    <= '0;
            fmt_q     <= '0;
            buf_q     <= '0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            if (take_start) begin
                restore_q <= op_restore;
                id_q      <= op_cpid;
                base_q    <= ea_addr;
                err_q     <= 1'b0;
            end
            if ((state_q == ST_READ_FMT) && src_ack) begin
                fmt_q <= restore_q ? mem_rdata[FMT_W-1:0] : cp_rdata[FMT_W-1:0];
            end
            if ((state_q == ST_XFER) && (phase_q == PH_SRC) && src_ack) begin
                buf_q <= restore_q ? mem_rdata : cp_rdata;
            end
            if ((state_q == ST_ABORT) && cp_ack) begin
                err_q <= 1'b1;
            end
        end
    end

    // port outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE) && !err_q;
        fmt_err   = (state_q == ST_DONE) &&  err_q;
        cp_req    = 1'b0;
        cp_we     = 1'b0;
        cp_id     = id_q;
        cp_sel    = CPR_CTRL;
        cp_wdata  = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base_q;
        mem_wdata = '0;
        unique case (state_q)
            ST_READ_FMT: begin
                if (restore_q) begin
                    mem_req  = 1'b1;
                    mem_addr = base_q;
                end else begin
                    cp_req = 1'b1;
                    cp_sel = CPR_SAVE;
                end
            end
            ST_XFER: begin
                unique case (phase_q)
                    PH_FMT: begin
                        if (restore_q) begin
                            cp_req   = 1'b1;
                            cp_we    = 1'b1;
                            cp_sel   = CPR_RESTORE;
                            cp_wdata = DW'(fmt_q);
                        end else begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = base_q;
                            mem_wdata = DW'(fmt_q);
                        end
                    end
                    PH_SRC: begin
                        if (restore_q) begin
                            mem_req  = 1'b1;
                            mem_addr = frame_addr;
                        end else begin
                            cp_req = 1'b1;
                            cp_sel = CPR_OPERAND;
                        end
                    end
                    PH_DST: begin
                        if (restore_q) begin
                            cp_req   = 1'b1;
                            cp_we    = 1'b1;
                            cp_sel   = CPR_OPERAND;
                            cp_wdata = buf_q;
                        end else begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = frame_addr;
                            mem_wdata = buf_q;
                        end
                    end
                    default: ;
                endcase
            end
            ST_ABORT: begin
                cp_req   = 1'b1;
                cp_we    = 1'b1;
                cp_sel   = CPR_CTRL;
                cp_wdata = ABORT_MASK;
            end
            default: ;
        endcase
    end

    AST_ABORT_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_req && cp_we && cp_ack && (cp_sel == CPR_CTRL)) |=> fmt_err); // R4
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_ack || cp_ack)); // R9
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fmt_err)); // R9
    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fmt_err) |=> !busy); // R1
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && cp_req)); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R10
    AST_CP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_req && !cp_ack) |=> (cp_req && $stable(cp_sel) && $stable(cp_we)
                                 && $stable(cp_wdata) && $stable(cp_id))); // R10

endmodule

// File: tb/sim_cpctx_seq.sv
`timescale 1ns/1ps
module sim_cpctx_seq;

    localparam logic [31:0] ABORT_MASK = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_restore = 1'b0;
    logic [2:0]  op_cpid = '0;
    logic [31:0] ea_addr = '0;
    logic        busy, done, fmt_err;
    logic        cp_req, cp_we;
    logic [2:0]  cp_id;
    logic [1:0]  cp_sel;
    logic [31:0] cp_wdata;
    logic [31:0] cp_rdata = '0;
    logic        cp_ack = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2 clk = ~clk;

    cpctx_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_restore(op_restore),
        .op_cpid(op_cpid), .ea_addr(ea_addr), .busy(busy), .done(done),
        .fmt_err(fmt_err), .cp_req(cp_req), .cp_we(cp_we), .cp_id(cp_id),
        .cp_sel(cp_sel), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
        .cp_ack(cp_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    int total = 0;
    int bad   = 0;

    // memory image read by the model, written only by the stimulus
    logic [31:0] img [0:1023];
    logic [15:0] save_fmt = '0;
    logic [7:0]  op_seed  = '0;
    int          rd_base  = 0;

    // transaction trace: {kind, address/select, data}
    // kind 0 cp read, 1 cp write, 2 mem read, 3 mem write
    logic [65:0] trc [0:8191];
    int          trc_n = 0;
    int          cp_rd_cnt = 0;
    int          mem_lat = 0;
    int          cp_lat  = 0;
    int          overlap_cnt = 0;
    logic [31:0] rv;

    task automatic log_ev(input logic [65:0] e);
        if (trc_n < 8192) trc[trc_n] = e;
        trc_n++;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            cp_ack  <= 1'b0;
            mem_lat = 0;
            cp_lat  = 0;
        end else begin
            if (mem_ack) mem_ack <= 1'b0;
            else if (mem_req) begin
                if (mem_lat == 0) begin
                    mem_ack <= 1'b1;
                    mem_lat = $urandom % 3;
                    if (mem_we) log_ev({2'd3, mem_addr, mem_wdata});
                    else begin
                        rv = img[mem_addr[11:2]];
                        mem_rdata <= rv;
                        log_ev({2'd2, mem_addr, rv});
                    end
                end else mem_lat = mem_lat - 1;
            end
            if (cp_ack) cp_ack <= 1'b0;
            else if (cp_req) begin
                if (cp_lat == 0) begin
                    cp_ack <= 1'b1;
                    cp_lat = $urandom % 3;
                    if (cp_we) log_ev({2'd1, {27'h0, cp_id, cp_sel}, cp_wdata});
                    else begin
                        if (cp_sel == 2'd1) rv = {16'h0, save_fmt};
                        else if (cp_sel == 2'd3) begin
                            rv = {8'hA5, op_seed, 8'h00, 8'(cp_rd_cnt - rd_base)};
                            cp_rd_cnt++;
                        end else rv = 32'h0;
                        cp_rdata <= rv;
                        log_ev({2'd0, {27'h0, cp_id, cp_sel}, rv});
                    end
                end else cp_lat = cp_lat - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_req && cp_req) overlap_cnt++;
    end

    function automatic bit fmt_bad(input logic [15:0] f);
        return (f == 16'h0100) || (f[1:0] != 2'b00);
    endfunction

    function automatic logic [31:0] cpa(input logic [2:0] id, input logic [1:0] sel);
        return {27'h0, id, sel};
    endfunction

    logic [65:0] exp_t [0:255];
    int          exp_n;

    task automatic push(input logic [65:0] e);
        exp_t[exp_n] = e;
        exp_n++;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [65:0] act, input logic [65:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic run_op(input bit rst_op, input logic [2:0] id, input int bidx,
                          input logic [15:0] f, input logic [7:0] seed,
                          input bit poke, input string tag);
        logic [31:0] base;
        int          nw, st, ov0, cyc;
        bit          isbad, ok;
        logic [31:0] d;
        base = 32'(bidx * 4);
        nw   = int'(f[7:2]);
        isbad = fmt_bad(f);
        if (rst_op) begin
            img[bidx] = {16'($urandom), f};
            for (int k = 0; k < nw; k++) img[bidx + 1 + k] = $urandom;
        end
        save_fmt = f;
        op_seed  = seed;
        rd_base  = cp_rd_cnt;
        exp_n = 0;
        if (!rst_op) push({2'd0, cpa(id, 2'd1), {16'h0, f}});
        else         push({2'd2, base, img[bidx]});
        if (isbad) push({2'd1, cpa(id, 2'd0), ABORT_MASK});
        else if (!rst_op) begin
            push({2'd3, base, {16'h0, f}});
            for (int k = 0; k < nw; k++) begin
                d = {8'hA5, seed, 8'h00, 8'(k)};
                push({2'd0, cpa(id, 2'd3), d});
                push({2'd3, base + 32'(4 + 4 * k), d});
            end
        end else begin
            push({2'd1, cpa(id, 2'd2), {16'h0, f}});
            for (int k = 0; k < nw; k++) begin
                d = img[bidx + 1 + k];
                push({2'd2, base + 32'(4 + 4 * k), d});
                push({2'd1, cpa(id, 2'd3), d});
            end
        end
        st  = trc_n;
        ov0 = overlap_cnt;
        @(negedge clk);
        op_restore = rst_op; op_cpid = id; ea_addr = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", {tag, " busy after start"}, 66'(busy), 66'd1);
        if (poke) begin
            @(negedge clk);
            op_restore = ~rst_op; op_cpid = ~id; ea_addr = base + 32'h40; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!(done || fmt_err) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 3000) begin
            chk(1'b0, tag, "operation timeout", 66'(cyc), 66'd0);
        end else begin
            chk(isbad ? (fmt_err && !done) : (done && !fmt_err), isbad ? "R4/R5" : "R9",
                {tag, " outcome {done,fmt_err}"}, 66'({done, fmt_err}),
                66'(isbad ? 2'b01 : 2'b10));
            @(negedge clk);
            chk(!done && !fmt_err && !busy, "R9", {tag, " single pulse then idle"},
                66'({done, fmt_err, busy}), 66'd0);
        end
        chk((trc_n - st) == exp_n, tag, "trace length", 66'(trc_n - st), 66'(exp_n));
        if ((trc_n - st) == exp_n) begin
            ok = 1'b1;
            for (int i = 0; i < exp_n; i++) begin
                if (ok && trc[st + i] !== exp_t[i]) begin
                    ok = 1'b0;
                    chk(1'b0, tag, $sformatf("trace entry %0d", i), trc[st + i], exp_t[i]);
                end
            end
            if (ok) chk(1'b1, tag, "trace", 66'd0, 66'd0);
        end
        chk(overlap_cnt == ov0, "R10", {tag, " port overlap"}, 66'(overlap_cnt - ov0), 66'd0);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] f;
        int kind;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) img[i] = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !fmt_err && !cp_req && !mem_req, "R11", "in reset",
            66'({busy, done, fmt_err, cp_req, mem_req}), 66'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fmt_err && !cp_req && !mem_req, "R11", "after reset",
            66'({busy, done, fmt_err, cp_req, mem_req}), 66'd0);

        run_op(1'b0, 3'd1, 10, 16'h2208, 8'h11, 1'b0, "R6 R2 save len8");
        run_op(1'b0, 3'd5, 20, 16'h0100, 8'h12, 1'b0, "R4 save busy word");
        run_op(1'b0, 3'd2, 30, 16'h3306, 8'h13, 1'b0, "R5 save len6");
        run_op(1'b1, 3'd3, 40, 16'h440C, 8'h14, 1'b0, "R7 R3 restore len12");
        run_op(1'b1, 3'd4, 60, 16'h5500, 8'h15, 1'b0, "R8 restore len0");
        run_op(1'b0, 3'd6, 70, 16'h6600, 8'h16, 1'b0, "R8 save len0");
        run_op(1'b1, 3'd7, 80, 16'h0100, 8'h17, 1'b0, "R4 restore invalid");
        run_op(1'b1, 3'd0, 90, 16'h7702, 8'h18, 1'b0, "R5 restore len2");
        run_op(1'b0, 3'd2, 0,  16'h01FC, 8'h19, 1'b0, "R6 save len252");
        run_op(1'b1, 3'd1, 100, 16'h01FC, 8'h1A, 1'b0, "R7 restore len252");
        run_op(1'b0, 3'd3, 200, 16'h8810, 8'h1B, 1'b1, "R1 start while busy");

        for (int n = 0; n < 30; n++) begin
            kind = int'($urandom % 4);
            if (kind == 0)      f = 16'h0100;
            else if (kind == 1) f = {8'($urandom), 6'($urandom), 2'(1 + ($urandom % 3))};
            else                f = {8'($urandom), 2'b00, 4'($urandom), 2'b00};
            run_op(1'($urandom), 3'($urandom), int'($urandom % 180), f, 8'($urandom),
                   1'b0, "R6 R7 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule